// File: doc/BRIEF.md
# Late Execution and Commit-Time Prediction Check

This block sits just in front of retirement in a core that uses value prediction. Each cycle it can accept one group of up to `N` micro-ops in program order. For each op it receives the register operands and an op class. An internal in-order queue holds the predicted values. Fetch pushes predicted values into this queue, one per cycle. The group pops them in slot order, one for each slot that carries a prediction.

The block does the following for each group:

- It computes single-cycle ALU ops whose results were predicted.
- It resolves conditional branches that were handed over as very high confidence.
- It compares each predicted result against the true one.

A failing comparison requests a full pipeline squash. The squash points at the oldest failing slot, and the prediction queue is emptied. The block also reports which slots may retire and which results feed predictor training.

An op may read the predicted result of an older predicted op in the same group instead of its register operand, so nothing in a group ever waits. Condition flags are not stored with a prediction. They are rebuilt from the predicted value with fixed approximations, and a flag that disagrees counts as a misprediction. The exception is the nibble-carry flag, which is never compared.

Top module: `late_exec_validate`

## Requirements
- R1: While `rst_ni` is low and on the first edges after it rises with no group offered, `out_vld_o`, `commit_o`, `squash_o`, `train_vld_o` and `res_o` are zero, and the prediction queue is empty.
- R2: A slot of class ALU (`slot_kind` 1) computes `a+b`, `a-b`, `a&b` or `a^b` for `slot_fn` 0, 1, 2 or 3. An external slot (`slot_kind` 3) passes `act_i` through. Branch (2) and plain (0) slots report a zero result on `res_o`.
- R3: An operand of slot i whose forward enable is set takes the predicted value of slot j (`fwd*_idx`) only if j < i and slot j is valid and predicted. Otherwise it takes the register operand.
- R4: Valid predicted slots take queue entries oldest-first in ascending slot order, and a group pops exactly that many entries.
- R5: A predicted ALU slot fails when either of these holds: the value differs from its prediction, or the rebuilt flags differ from the computed flags. The rebuilt flags are zero, sign, even parity of the low byte, carry equal to the predicted sign bit, and overflow equal to 0. The nibble carry is ignored.
- R6: A branch slot (`slot_kind` 2) evaluates EQ, NE, signed LT or signed GE for `slot_fn` 0 to 3 and fails when the outcome differs from `slot_taken_i`.
- R7: An external slot with a prediction fails on a value mismatch. If it was early-executed (`slot_ee_i`), it is checked only when `slot_eeuse_i` is set.
- R8: When any valid slot fails, `squash_o` rises and `squash_idx_o` names the lowest failing slot. `commit_o` then holds the valid slots up to and including that one. With no failure, every valid slot commits.
- R9: A group that squashes empties the prediction queue, and a push offered in that same cycle is dropped.
- R10: `train_vld_o` marks committed ALU and external slots, whether predicted or not.
- R11: A push is accepted only if the queue held fewer than `D` entries before that cycle's pops.
- R12: Outputs for a group appear on the edge after `grp_vld_i`, with `out_vld_o` high for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pq_push_i | input | 1 | Push a predicted value |
| pq_data_i | input | W | Predicted value to push |
| grp_vld_i | input | 1 | A commit group is offered |
| slot_vld_i | input | N | Slot holds an op |
| slot_kind_i | input | 2*N | Op class per slot: 0 plain, 1 ALU, 2 branch, 3 external |
| slot_fn_i | input | 2*N | ALU function or branch condition per slot |
| slot_pred_i | input | N | Slot has a queue entry |
| slot_ee_i | input | N | External slot was early-executed |
| slot_eeuse_i | input | N | Its prediction was consumed in the early stage |
| slot_taken_i | input | N | Predicted branch direction |
| opa_i | input | N*W | First register operand per slot |
| opb_i | input | N*W | Second register operand per slot |
| act_i | input | N*W | True result of external slots |
| fwda_en_i | input | N | First operand reads an older prediction |
| fwdb_en_i | input | N | Second operand reads an older prediction |
| fwda_idx_i | input | N*IW | Producer slot for the first operand |
| fwdb_idx_i | input | N*IW | Producer slot for the second operand |
| out_vld_o | output | 1 | Group result valid |
| commit_o | output | N | Slots allowed to retire |
| squash_o | output | 1 | Full pipeline squash request |
| squash_idx_o | output | IW | Oldest failing slot |
| train_vld_o | output | N | Slots whose result trains the predictor |
| res_o | output | N*W | True result per slot |

## Verification
The bench targets several corner cases, and each one catches a specific class of wrong design:

- **Flag approximations.** An add into the sign bit with overflow, an add carrying out to zero, an add carrying out into a negative result, a nibble carry, and an AND with a negative result. A design that compared the nibble carry, or that took carry from the true operands, would squash the wrong groups.
- **Forwarding.** Forwards are aimed at a younger slot and at an older predicted slot. A design that did not restrict forwarding to older predicted slots would produce wrong results.
- **Queue handling.** One check places a push in the same cycle as a squash, and another pushes into a full queue while it pops. A design that kept stale entries, or sized acceptance after the pops, would shift every later prediction.
- **Multiple failures and holes.** Groups with two failing slots and an empty slot between them would expose a design that squashed at the youngest failure or committed past it.

// File: rtl/lev_pkg.sv
package lev_pkg;
  typedef enum logic [1:0] {K_NONE = 2'd0, K_ALU = 2'd1, K_BRC = 2'd2, K_EXT = 2'd3} kind_e;
  typedef enum logic [1:0] {FN_ADD = 2'd0, FN_SUB = 2'd1, FN_AND = 2'd2, FN_XOR = 2'd3} alu_fn_e;
  typedef enum logic [1:0] {CC_EQ = 2'd0, CC_NE = 2'd1, CC_LT = 2'd2, CC_GE = 2'd3} cond_e;
  typedef struct packed {
    logic zf;
    logic sf;
    logic pf;
    logic cf;
    logic of;
    logic af;
  } flags_t;
endpackage

// File: rtl/lev_pred_fifo.sv
module lev_pred_fifo #(
  parameter int W = 16,
  parameter int D = 8,
  parameter int N = 4,
  localparam int AW = $clog2(D),
  localparam int CW = $clog2(D + 1),
  localparam int PW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  push_data_i,
  input  logic [PW-1:0] pop_cnt_i,
  input  logic          flush_i,
  output logic [N*W-1:0] win_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [D];
  logic [AW-1:0] head;
  logic [CW-1:0] cnt;
  logic          push_ok;
  logic [AW-1:0] tail;

  // acceptance judged on the occupancy before this cycle's pops
  assign push_ok = push_i && !flush_i && (cnt < CW'(D));
  assign tail    = head + AW'(cnt);
  assign cnt_o   = cnt;

  for (genvar j = 0; j < N; j++) begin : g_win
    assign win_o[j*W +: W] = mem[head + AW'(j)];
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[tail] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head <= '0;
      cnt  <= '0;
    end else if (flush_i) begin
      cnt <= '0;
    end else begin
      head <= head + AW'(pop_cnt_i);
      cnt  <= cnt - CW'(pop_cnt_i) + CW'(push_ok);
    end
  end
endmodule

// File: rtl/lev_slot_exec.sv
module lev_slot_exec import lev_pkg::*; #(
  parameter int W = 16
) (
  input  logic [1:0]   kind_i,
  input  logic [1:0]   fn_i,
  input  logic         pred_i,
  input  logic         ee_i,
  input  logic         eeuse_i,
  input  logic         taken_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] pv_i,
  input  logic [W-1:0] act_i,
  output logic         fail_o,
  output logic         train_o,
  output logic [W-1:0] res_o
);
  logic [W:0]   sum, dif;
  logic [W-1:0] r;
  flags_t       fa, fp;
  logic         flag_bad, tk;

  always_comb begin
    sum   = {1'b0, a_i} + {1'b0, b_i};
    dif   = {1'b0, a_i} - {1'b0, b_i};
    r     = '0;
    fa    = '0;
    unique case (alu_fn_e'(fn_i))
      FN_ADD: begin
        r     = sum[W-1:0];
        fa.cf = sum[W];
        fa.of = (a_i[W-1] == b_i[W-1]) && (r[W-1] != a_i[W-1]);
        fa.af = a_i[4] ^ b_i[4] ^ r[4];
      end
      FN_SUB: begin
        r     = dif[W-1:0];
        fa.cf = dif[W];
        fa.of = (a_i[W-1] != b_i[W-1]) && (r[W-1] != a_i[W-1]);
        fa.af = a_i[4] ^ b_i[4] ^ r[4];
      end
      FN_AND: r = a_i & b_i;
      default: r = a_i ^ b_i;
    endcase
    fa.zf = (r == '0);
    fa.sf = r[W-1];
    fa.pf = ~^r[7:0];
    // flags rebuilt from the prediction alone
    fp.zf = (pv_i == '0);
    fp.sf = pv_i[W-1];
    fp.pf = ~^pv_i[7:0];
    fp.cf = pv_i[W-1];
    fp.of = 1'b0;
    fp.af = 1'b0;
    flag_bad = (fa.zf != fp.zf) || (fa.sf != fp.sf) || (fa.pf != fp.pf) ||
               (fa.cf != fp.cf) || (fa.of != fp.of);

    unique case (cond_e'(fn_i))
      CC_EQ: tk = (a_i == b_i);
      CC_NE: tk = (a_i != b_i);
      CC_LT: tk = ($signed(a_i) < $signed(b_i));
      default: tk = ($signed(a_i) >= $signed(b_i));
    endcase

    fail_o  = 1'b0;
    train_o = 1'b0;
    res_o   = '0;
    unique case (kind_e'(kind_i))
      K_ALU: begin
        res_o   = r;
        train_o = 1'b1;
        fail_o  = pred_i && ((pv_i != r) || flag_bad);
      end
      K_BRC: fail_o = (tk != taken_i);
      K_EXT: begin
        res_o   = act_i;
        train_o = 1'b1;
        fail_o  = pred_i && (!ee_i || eeuse_i) && (pv_i != act_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/late_exec_validate.sv
module late_exec_validate import lev_pkg::*; #(
  parameter int W = 16,
  parameter int N = 4,
  parameter int D = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int PW = $clog2(N + 1),
  localparam int CW = $clog2(D + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pq_push_i,
  input  logic [W-1:0]    pq_data_i,
  input  logic            grp_vld_i,
  input  logic [N-1:0]    slot_vld_i,
  input  logic [2*N-1:0]  slot_kind_i,
  input  logic [2*N-1:0]  slot_fn_i,
  input  logic [N-1:0]    slot_pred_i,
  input  logic [N-1:0]    slot_ee_i,
  input  logic [N-1:0]    slot_eeuse_i,
  input  logic [N-1:0]    slot_taken_i,
  input  logic [N*W-1:0]  opa_i,
  input  logic [N*W-1:0]  opb_i,
  input  logic [N*W-1:0]  act_i,
  input  logic [N-1:0]    fwda_en_i,
  input  logic [N-1:0]    fwdb_en_i,
  input  logic [N*IW-1:0] fwda_idx_i,
  input  logic [N*IW-1:0] fwdb_idx_i,
  output logic            out_vld_o,
  output logic [N-1:0]    commit_o,
  output logic            squash_o,
  output logic [IW-1:0]   squash_idx_o,
  output logic [N-1:0]    train_vld_o,
  output logic [N*W-1:0]  res_o
);
  logic [N*W-1:0] win_flat;
  logic [W-1:0]   win   [N];
  logic [W-1:0]   pv    [N];
  logic [W-1:0]   a_op  [N];
  logic [W-1:0]   b_op  [N];
  logic [W-1:0]   res_v [N];
  logic [N-1:0]   fail_raw, train_raw, fail_v, cmt;
  logic [PW-1:0]  pop_cnt;
  logic [CW-1:0]  pq_cnt;
  logic [IW-1:0]  fidx;
  logic           any_fail, flush;

  lev_pred_fifo #(.W(W), .D(D), .N(N)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(pq_push_i), .push_data_i(pq_data_i),
    .pop_cnt_i(pop_cnt), .flush_i(flush),
    .win_o(win_flat), .cnt_o(pq_cnt)
  );

  // rank of each slot among the group's predicted slots
  always_comb begin
    logic [PW-1:0] rk;
    rk = '0;
    for (int i = 0; i < N; i++) begin
      win[i] = win_flat[i*W +: W];
    end
    for (int i = 0; i < N; i++) begin
      pv[i] = win[rk[IW-1:0]];
      if (slot_vld_i[i] && slot_pred_i[i]) rk = rk + PW'(1);
    end
    pop_cnt = grp_vld_i ? rk : '0;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [IW-1:0] ia, ib;
    assign ia = fwda_idx_i[i*IW +: IW];
    assign ib = fwdb_idx_i[i*IW +: IW];

    always_comb begin
      a_op[i] = opa_i[i*W +: W];
      b_op[i] = opb_i[i*W +: W];
      if (fwda_en_i[i] && (int'(ia) < i) && slot_vld_i[ia] && slot_pred_i[ia]) a_op[i] = pv[ia];
      if (fwdb_en_i[i] && (int'(ib) < i) && slot_vld_i[ib] && slot_pred_i[ib]) b_op[i] = pv[ib];
    end

    lev_slot_exec #(.W(W)) u_exec (
      .kind_i(slot_kind_i[2*i +: 2]), .fn_i(slot_fn_i[2*i +: 2]),
      .pred_i(slot_pred_i[i]), .ee_i(slot_ee_i[i]), .eeuse_i(slot_eeuse_i[i]),
      .taken_i(slot_taken_i[i]), .a_i(a_op[i]), .b_i(b_op[i]), .pv_i(pv[i]),
      .act_i(act_i[i*W +: W]), .fail_o(fail_raw[i]), .train_o(train_raw[i]),
      .res_o(res_v[i])
    );
  end

  always_comb begin
    fail_v   = fail_raw & slot_vld_i;
    any_fail = |fail_v;
    fidx     = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (fail_v[k]) fidx = IW'(k);
    end
    for (int k = 0; k < N; k++) begin
      cmt[k] = slot_vld_i[k] && (!any_fail || (k <= int'(fidx)));
    end
  end

  assign flush = grp_vld_i && any_fail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o    <= 1'b0;
      commit_o     <= '0;
      squash_o     <= 1'b0;
      squash_idx_o <= '0;
      train_vld_o  <= '0;
      res_o        <= '0;
    end else begin
      out_vld_o    <= grp_vld_i;
      commit_o     <= grp_vld_i ? cmt : '0;
      squash_o     <= flush;
      squash_idx_o <= flush ? fidx : '0;
      train_vld_o  <= grp_vld_i ? (cmt & train_raw) : '0;
      for (int k = 0; k < N; k++) begin
        res_o[k*W +: W] <= (grp_vld_i && slot_vld_i[k]) ? res_v[k] : '0;
      end
    end
  end
endmodule

// File: rtl/late_exec_validate_chk.sv
module late_exec_validate_chk #(
  parameter int N  = 4,
  parameter int D  = 8,
  parameter int IW = 2,
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          grp_vld_i,
  input logic          out_vld_o,
  input logic [N-1:0]  commit_o,
  input logic          squash_o,
  input logic [IW-1:0] squash_idx_o,
  input logic [N-1:0]  train_vld_o,
  input logic [CW-1:0] pq_cnt_i
);
  AST_GRP_TO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_vld_i |=> out_vld_o); // R12
  AST_IDLE_TO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_vld_i |=> !out_vld_o); // R12
  AST_QUIET_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> (commit_o == '0 && !squash_o && train_vld_o == '0)); // R1
  AST_SQUASH_SLOT_COMMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> commit_o[squash_idx_o]); // R8
  AST_SQUASH_NO_YOUNGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> ((commit_o >> (int'(squash_idx_o) + 1)) == '0)); // R8
  AST_TRAIN_COMMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (train_vld_o & ~commit_o) == '0); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (pq_cnt_i == '0)); // R9
  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pq_cnt_i <= CW'(D)); // R11
endmodule

bind late_exec_validate late_exec_validate_chk #(.N(N), .D(D), .IW(IW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .grp_vld_i(grp_vld_i), .out_vld_o(out_vld_o),
  .commit_o(commit_o), .squash_o(squash_o), .squash_idx_o(squash_idx_o),
  .train_vld_o(train_vld_o), .pq_cnt_i(pq_cnt)
);

// File: tb/sim_late_exec_validate.sv
`timescale 1ns/1ps
module sim_late_exec_validate;
  localparam int W = 16;
  localparam int N = 4;
  localparam int D = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pq_push;
  logic [W-1:0] pq_data;
  logic grp_vld;
  logic [N-1:0] slot_vld, slot_pred, slot_ee, slot_eeuse, slot_taken, fwda_en, fwdb_en;
  logic [2*N-1:0] slot_kind, slot_fn;
  logic [N*W-1:0] opa, opb, act;
  logic [N*IW-1:0] fwda_idx, fwdb_idx;
  logic out_vld, squash;
  logic [N-1:0] commit, train_vld;
  logic [IW-1:0] squash_idx;
  logic [N*W-1:0] res;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] q[$];

  logic e_vld, e_sq;
  logic [N-1:0] e_cmt, e_trn;
  int e_idx;
  logic [W-1:0] e_res [N];

  always #2.5 clk = ~clk;

  late_exec_validate #(.W(W), .N(N), .D(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pq_push_i(pq_push), .pq_data_i(pq_data),
    .grp_vld_i(grp_vld), .slot_vld_i(slot_vld), .slot_kind_i(slot_kind), .slot_fn_i(slot_fn),
    .slot_pred_i(slot_pred), .slot_ee_i(slot_ee), .slot_eeuse_i(slot_eeuse),
    .slot_taken_i(slot_taken), .opa_i(opa), .opb_i(opb), .act_i(act),
    .fwda_en_i(fwda_en), .fwdb_en_i(fwdb_en), .fwda_idx_i(fwda_idx), .fwdb_idx_i(fwdb_idx),
    .out_vld_o(out_vld), .commit_o(commit), .squash_o(squash), .squash_idx_o(squash_idx),
    .train_vld_o(train_vld), .res_o(res)
  );

  task automatic clr();
    pq_push = 0; pq_data = '0; grp_vld = 0; slot_vld = '0; slot_pred = '0;
    slot_ee = '0; slot_eeuse = '0; slot_taken = '0; fwda_en = '0; fwdb_en = '0;
    slot_kind = '0; slot_fn = '0; opa = '0; opb = '0; act = '0;
    fwda_idx = '0; fwdb_idx = '0;
  endtask

  task automatic set_slot(int i, logic [1:0] k, logic [1:0] f, logic p,
                          logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] ac);
    grp_vld = 1; slot_vld[i] = 1; slot_kind[2*i +: 2] = k; slot_fn[2*i +: 2] = f;
    slot_pred[i] = p; opa[i*W +: W] = a; opb[i*W +: W] = b; act[i*W +: W] = ac;
  endtask

  task automatic chk(string req, string tag, longint got, longint exp);
    if (got != exp) begin
      errors++;
      $display("FAIL %s [%s]: got %0h expected %0h", req, tag, got, exp);
    end
  endtask

  // reference model, then one clock, then compare
  task automatic step(string tag);
    logic [W-1:0] pvs [N];
    logic [W-1:0] va, vb, rv;
    logic fl [N];
    int rank, sz, first, pop;
    bit anyf, pushok;
    rank = 0;
    for (int i = 0; i < N; i++) begin
      pvs[i] = '0;
      if (slot_vld[i] && slot_pred[i]) begin
        if (rank < q.size()) pvs[i] = q[rank];
        rank++;
      end
    end
    pop = grp_vld ? rank : 0;
    first = -1;
    for (int i = 0; i < N; i++) begin
      int ia, ib, k, f, ua, ub, sa, sb, full, s;
      bit cf, of, tk;
      ia = fwda_idx[i*IW +: IW]; ib = fwdb_idx[i*IW +: IW];
      va = opa[i*W +: W]; vb = opb[i*W +: W];
      if (fwda_en[i] && ia < i && slot_vld[ia] && slot_pred[ia]) va = pvs[ia];
      if (fwdb_en[i] && ib < i && slot_vld[ib] && slot_pred[ib]) vb = pvs[ib];
      k = slot_kind[2*i +: 2]; f = slot_fn[2*i +: 2];
      ua = int'(va); ub = int'(vb); sa = int'($signed(va)); sb = int'($signed(vb));
      rv = '0; cf = 0; of = 0; fl[i] = 0;
      case (f)
        0: begin full = ua + ub; rv = W'(full); cf = full > 65535; s = sa + sb;
                 of = (s > 32767) || (s < -32768); end
        1: begin rv = W'(ua - ub); cf = ua < ub; s = sa - sb;
                 of = (s > 32767) || (s < -32768); end
        2: rv = va & vb;
        default: rv = va ^ vb;
      endcase
      case (f)
        0: tk = (va == vb);
        1: tk = (va != vb);
        2: tk = (sa < sb);
        default: tk = (sa >= sb);
      endcase
      e_res[i] = '0;
      if (grp_vld && slot_vld[i]) begin
        if (k == 1) begin
          e_res[i] = rv;
          fl[i] = slot_pred[i] && !((pvs[i] == rv) && (cf == pvs[i][W-1]) && !of);
        end else if (k == 2) begin
          fl[i] = (tk != slot_taken[i]);
        end else if (k == 3) begin
          e_res[i] = act[i*W +: W];
          fl[i] = slot_pred[i] && (!slot_ee[i] || slot_eeuse[i]) && (pvs[i] != act[i*W +: W]);
        end
        if (fl[i] && first < 0) first = i;
      end
    end
    anyf = grp_vld && (first >= 0);
    e_vld = grp_vld; e_sq = anyf; e_idx = anyf ? first : 0;
    for (int i = 0; i < N; i++) begin
      int k;
      k = slot_kind[2*i +: 2];
      e_cmt[i] = grp_vld && slot_vld[i] && (!anyf || i <= first);
      e_trn[i] = e_cmt[i] && (k == 1 || k == 3);
    end
    sz = q.size();
    pushok = pq_push && (sz < D) && !anyf;
    if (anyf) q.delete();
    else begin
      for (int p = 0; p < pop; p++) void'(q.pop_front());
      if (pushok) q.push_back(pq_data);
    end
    @(negedge clk);
    vectors++;
    chk("R12", tag, out_vld, e_vld);
    chk("R8", tag, commit, e_cmt);
    chk("R8", tag, squash, e_sq);
    chk("R8", tag, squash_idx, e_idx);
    chk("R10", tag, train_vld, e_trn);
    for (int i = 0; i < N; i++) chk("R2", tag, res[i*W +: W], e_res[i]);
    clr();
  endtask

  task automatic push(logic [W-1:0] v, string tag);
    pq_push = 1; pq_data = v;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    vectors++;
    chk("R1", "reset", {out_vld, squash, commit, train_vld}, 0);
    chk("R1", "reset res", res, 0);
    rst_ni = 1;
    step("R1 idle"); step("R1 idle");

    // R2 R4: four ALU ops consume predictions in slot order
    push(16'h0003, "R4 push"); push(16'h0003, "R4 push");
    push(16'h00F0, "R4 push"); push(16'h0002, "R4 push");
    set_slot(0, 1, 0, 1, 16'h0001, 16'h0002, 0);
    set_slot(1, 1, 1, 1, 16'h0005, 16'h0002, 0);
    set_slot(2, 1, 2, 1, 16'hF0F0, 16'h0FFF, 0);
    set_slot(3, 1, 3, 1, 16'h0001, 16'h0003, 0);
    step("R2 R4 alu group");

    // R3: forward from older predicted slot; forward from younger ignored
    push(16'h0010, "R3 push"); push(16'h0011, "R3 push");
    set_slot(0, 1, 0, 1, 16'h0008, 16'h0008, 0);
    set_slot(1, 1, 0, 1, 16'h0999, 16'h0001, 0);
    fwda_en[1] = 1; fwda_idx[1*IW +: IW] = 0;
    set_slot(2, 1, 3, 0, 16'h0005, 16'h0005, 0);
    fwdb_en[2] = 1; fwdb_idx[2*IW +: IW] = 3;
    set_slot(3, 0, 0, 0, 0, 0, 0);
    step("R3 forward");

    // R3: forward from an unpredicted older slot uses the register
    set_slot(0, 1, 0, 0, 16'h0100, 16'h0001, 0);
    set_slot(1, 1, 0, 0, 16'h0020, 16'h0002, 0);
    fwda_en[1] = 1; fwda_idx[1*IW +: IW] = 0;
    step("R3 unpredicted producer");

    // R5: overflow into sign fails at slot 1
    push(16'h0005, "R5 push"); push(16'h8000, "R5 push");
    set_slot(0, 1, 0, 1, 16'h0002, 16'h0003, 0);
    set_slot(1, 1, 0, 1, 16'h4000, 16'h4000, 0);
    set_slot(2, 1, 0, 0, 16'h0001, 16'h0001, 0);
    set_slot(3, 3, 0, 0, 0, 0, 16'h0007);
    step("R5 overflow");

    push(16'h0000, "R5 push");
    set_slot(0, 1, 0, 1, 16'hFFFF, 16'h0001, 0);
    step("R5 carry out to zero");

    push(16'h8000, "R5 push"); push(16'h0010, "R5 push");
    set_slot(0, 1, 0, 1, 16'hFFFF, 16'h8001, 0);
    set_slot(1, 1, 0, 1, 16'h000F, 16'h0001, 0);
    step("R5 carry equals sign, nibble carry ignored");

    push(16'h8000, "R5 push");
    set_slot(0, 1, 2, 1, 16'h8000, 16'h8000, 0);
    step("R5 logical negative");

    // R6: branch conditions
    set_slot(0, 2, 0, 0, 16'h0005, 16'h0005, 0); slot_taken[0] = 1;
    set_slot(1, 2, 1, 0, 16'h0005, 16'h0005, 0); slot_taken[1] = 0;
    set_slot(2, 2, 2, 0, 16'hFFFF, 16'h0001, 0); slot_taken[2] = 0;
    set_slot(3, 2, 3, 0, 16'h0001, 16'h0002, 0); slot_taken[3] = 0;
    step("R6 branch mispredict");
    set_slot(0, 2, 3, 0, 16'h0001, 16'hFFFF, 0); slot_taken[0] = 1;
    set_slot(1, 2, 2, 0, 16'h0001, 16'hFFFF, 0); slot_taken[1] = 0;
    step("R6 signed compare");

    // R7: early-executed prediction checked only when consumed
    push(16'h1111, "R7 push"); push(16'h2222, "R7 push"); push(16'h3333, "R7 push");
    set_slot(0, 3, 0, 1, 0, 0, 16'h9999); slot_ee[0] = 1;
    set_slot(1, 3, 0, 1, 0, 0, 16'h2222);
    set_slot(2, 3, 0, 1, 0, 0, 16'h3330); slot_ee[2] = 1; slot_eeuse[2] = 1;
    set_slot(3, 3, 0, 0, 0, 0, 16'h4444);
    step("R7 early executed");

    // R10: unpredicted eligible ops still train
    set_slot(0, 3, 0, 0, 0, 0, 16'hABCD);
    set_slot(1, 0, 0, 0, 0, 0, 0);
    set_slot(2, 1, 0, 0, 16'h0001, 16'h0001, 0);
    set_slot(3, 2, 0, 0, 16'h0001, 16'h0001, 0); slot_taken[3] = 1;
    step("R10 training");

    // R9: squash empties queue and drops concurrent push
    push(16'hAAAA, "R9 push"); push(16'hBBBB, "R9 push");
    set_slot(0, 3, 0, 1, 0, 0, 16'h0000);
    pq_push = 1; pq_data = 16'hCCCC;
    step("R9 squash with push");
    push(16'hDDDD, "R9 push");
    set_slot(0, 3, 0, 1, 0, 0, 16'hDDDD);
    step("R9 after flush");

    // R11: full queue drops push even when popping
    for (int v = 0; v < 8; v++) push(16'h0100 + W'(v), "R11 fill");
    push(16'h0EEE, "R11 push when full");
    for (int i = 0; i < 4; i++) set_slot(i, 3, 0, 1, 0, 0, 16'h0100 + W'(i));
    pq_push = 1; pq_data = 16'h0F0F;
    step("R11 pop with push at full");
    push(16'h0108, "R11 push");
    for (int i = 0; i < 4; i++) set_slot(i, 3, 0, 1, 0, 0, 16'h0104 + W'(i));
    step("R11 drain");
    set_slot(0, 3, 0, 1, 0, 0, 16'h0108);
    step("R11 accepted after room");

    // R8: two failures with a hole, oldest wins
    push(16'h0001, "R8 push"); push(16'h0002, "R8 push"); push(16'h0003, "R8 push");
    set_slot(0, 3, 0, 1, 0, 0, 16'h0001);
    set_slot(1, 3, 0, 1, 0, 0, 16'h0009);
    set_slot(3, 3, 0, 1, 0, 0, 16'h0000);
    step("R8 oldest failure");
    set_slot(0, 0, 0, 0, 0, 0, 0);
    set_slot(1, 1, 1, 0, 16'h0009, 16'h0001, 0);
    set_slot(3, 2, 0, 0, 16'h0001, 16'h0002, 0); slot_taken[3] = 1;
    step("R8 youngest failure");

    step("R12 idle"); step("R12 idle");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule